// File: doc/BRIEF.md
# Two-Space Serial Memory Slave with Busy Polling

This block is the slave side of a two-wire serial bus (I2C) placed in front of a small byte-addressed store. The store has two spaces. The first is a 512-byte data array organised as 32 pages of 16 bytes. The second is a 16-byte control space. The host picks a space by sending one of two 7-bit device identifiers. A two-byte word address, high byte first, sets an internal address counter. The host can then write one byte or up to a full page, or read back from the current address, from a random address or as a sequential stream.

Written bytes are first collected in a page buffer. They are committed only at a clean stop condition. The commit starts a self-timed write cycle. While that cycle runs, the slave refuses its own device identifier, so the host finds out that the write has finished by repeatedly addressing the device until it answers.

Changes to the control bytes are guarded by two enable flags in a status byte. The flags have to be raised in a fixed order before any other control byte will accept a new value. The bus lines are oversampled with the system clock. The data line is only ever pulled low.

Top module: `i2c_mem_slave`

## Requirements
- R1: The slave acknowledges the address byte when its upper 7 bits are 1010111 (data array) or 1101111 (control space); bit 0 of that byte selects read (1) or write (0). Any other identifier is not acknowledged, and the slave then leaves the bus alone, acknowledging nothing, until the next start condition.
- R2: After a write address byte, the next two bytes form the word address, high byte first. In the data array the address is bit 0 of the high byte followed by the 8 bits of the low byte. In the control space only the low 4 bits of the low byte are used.
- R3: Each acknowledged data byte goes to the current address. The address then steps only within its 16-byte page: the low 4 bits wrap and the page bits are kept. This holds for a single-byte write and for a page write of up to 16 bytes alike.
- R4: A stop condition that follows at least one fully acknowledged data byte commits the buffered bytes and starts a write cycle of WRITE_CYCLES clocks. During that cycle both device identifiers are refused (not acknowledged). Once the cycle ends, the device identifiers are acknowledged again.
- R5: A write whose final data byte is not complete and acknowledged when the stop arrives, or which is cut short by a repeated start, changes no stored byte and starts no write cycle.
- R6: A stop directly after the low word-address byte loads the address counter and starts no write cycle. A following current-address read returns the byte at that address.
- R7: Reads return the byte at the address counter, and the counter then increments. In the data array it wraps from 511 to 0. A repeated start after a write of the word address gives a random read. The read stream ends when the master does not acknowledge a byte.
- R8: Control index 15 is the status byte. On a write to it, bit 1 (write enable) takes the written bit 1. Bit 2 (register write enable) becomes 1 only if written bits 2 and 1 are both 1 and bit 1 was already set before the write. Reading index 15 returns 0 in all bits except bits 1 and 2. Addresses in the control space wrap from 15 to 0.
- R9: Control indexes 0 to 14 take a written value only when both enable bits were set before the commit; otherwise the written value is dropped.
- R10: The data line output is an active-high pull-low enable. It is 0 after reset and right after any start condition, and every byte of the data array reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
The bench goes after the places where the address counter has to wrap. A page write that starts at offset 12 must fold back to the page start; a design that carries into the page bits would corrupt the next page. A sequential read across 511 must come back at 0, and the control space must fold from 15 to 0. It aborts writes in two ways, once with a stop in the middle of a byte and once with a repeated start, and then reads the bytes back: a design that commits eagerly would show the new data and would refuse the next address byte. It walks the enable flags through the wrong order and the right order, and then re-locks them; a design that ignores the order would let a locked control byte change.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam logic [6:0] ID_MEM  = 7'b1010111;
    localparam logic [6:0] ID_CTRL = 7'b1101111;

    localparam int WEN_BIT  = 1;
    localparam int RWEN_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // returns {rwen, wen} after a write of wr_byte to the status byte
    function automatic logic [1:0] status_next(input logic [7:0] wr_byte, input logic wen_old);
        logic wen_n;
        logic rwen_n;
        wen_n  = wr_byte[WEN_BIT];
        rwen_n = wr_byte[RWEN_BIT] & wr_byte[WEN_BIT] & wen_old;
        return {rwen_n, wen_n};
    endfunction

endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync
    import i2c_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic scl_d, sda_d;
    logic scl_c, sda_c;

    assign scl_c = scl_sr[SYNC_STAGES-1];
    assign sda_c = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_c;
            sda_d  <= sda_c;
        end
    end

    always_comb begin
        ev.sda      = sda_c;
        ev.scl_rise = scl_c & ~scl_d;
        ev.scl_fall = ~scl_c & scl_d;
        ev.start    = scl_c & scl_d & sda_d & ~sda_c;
        ev.stop     = scl_c & scl_d & ~sda_d & sda_c;
    end
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store
    import i2c_mem_pkg::*;
#(
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int CTRL_BYTES   = 16,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           buf_clr,
    input  logic                           buf_we,
    input  logic                           buf_ctrl,
    input  logic [$clog2(MEM_DEPTH)-$clog2(PAGE_BYTES)-1:0] buf_page,
    input  logic [$clog2(PAGE_BYTES)-1:0]  buf_idx,
    input  logic [7:0]                     buf_data,
    input  logic                           commit,
    input  logic                           rd_ctrl,
    input  logic [$clog2(MEM_DEPTH)-1:0]   rd_addr,
    output logic [7:0]                     rd_data,
    output logic                           busy,
    output logic                           wen,
    output logic                           rwen
);
    localparam int ADDR_W     = $clog2(MEM_DEPTH);
    localparam int PAGE_AW    = $clog2(PAGE_BYTES);
    localparam int PG_W       = ADDR_W - PAGE_AW;
    localparam int CTRL_AW    = $clog2(CTRL_BYTES);
    localparam int STATUS_IDX = CTRL_BYTES - 1;
    localparam int CYC_W      = $clog2(WRITE_CYCLES + 1);

    logic [7:0]        mem_q  [MEM_DEPTH];
    logic [7:0]        ctrl_q [CTRL_BYTES];
    logic [7:0]        pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval_q;
    logic [PG_W-1:0]   page_q;
    logic              tgt_ctrl_q;
    logic              wen_q, rwen_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [7:0]        status_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
            for (int i = 0; i < CTRL_BYTES; i++) ctrl_q[i] <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
            pval_q     <= '0;
            page_q     <= '0;
            tgt_ctrl_q <= 1'b0;
            wen_q      <= 1'b0;
            rwen_q     <= 1'b0;
            cyc_q      <= '0;
        end else begin
            if (cyc_q != '0) cyc_q <= cyc_q - 1'b1;
            if (buf_clr) begin
                pval_q <= '0;
            end else if (buf_we) begin
                pbuf_q[buf_idx] <= buf_data;
                pval_q[buf_idx] <= 1'b1;
                page_q          <= buf_page;
                tgt_ctrl_q      <= buf_ctrl;
            end else if (commit) begin
                cyc_q  <= CYC_W'(WRITE_CYCLES);
                pval_q <= '0;
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (pval_q[i]) begin
                        if (!tgt_ctrl_q) begin
                            mem_q[{page_q, PAGE_AW'(i)}] <= pbuf_q[i];
                        end else if (i < CTRL_BYTES) begin
                            if (i == STATUS_IDX) begin
                                {rwen_q, wen_q} <= status_next(pbuf_q[i], wen_q);
                            end else if (wen_q && rwen_q) begin
                                ctrl_q[CTRL_AW'(i)] <= pbuf_q[i];
                            end
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        status_byte           = '0;
        status_byte[WEN_BIT]  = wen_q;
        status_byte[RWEN_BIT] = rwen_q;
        if (rd_ctrl) begin
            if (rd_addr[CTRL_AW-1:0] == CTRL_AW'(STATUS_IDX)) rd_data = status_byte;
            else rd_data = ctrl_q[rd_addr[CTRL_AW-1:0]];
        end else begin
            rd_data = mem_q[rd_addr];
        end
    end

    assign busy = (cyc_q != '0);
    assign wen  = wen_q;
    assign rwen = rwen_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int CTRL_BYTES   = 16,
    parameter int WRITE_CYCLES = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int ADDR_W  = $clog2(MEM_DEPTH);
    localparam int HI_W    = ADDR_W - 8;
    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int CTRL_AW = $clog2(CTRL_BYTES);

    bus_ev_t     ev;
    bus_st_e     st_q;
    rx_kind_e    kind_q;
    logic [3:0]  cnt_q;
    logic [7:0]  sh_q, txsh_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic ctrl_sp_q, rd_mode_q, mack_q, has_data_q, sda_oe_q;
    logic [7:0] rd_data;
    logic busy, wen, rwen;
    logic dev_hit, byte_done, buf_we, commit, start_det;

    function automatic logic [ADDR_W-1:0] read_step(input logic [ADDR_W-1:0] a, input logic in_ctrl);
        logic [ADDR_W-1:0] n;
        n = a + 1'b1;
        if (in_ctrl) begin
            n = a;
            n[CTRL_AW-1:0] = a[CTRL_AW-1:0] + 1'b1;
        end
        return n;
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a, input logic in_ctrl);
        logic [ADDR_W-1:0] n;
        n = a;
        if (in_ctrl) n[CTRL_AW-1:0] = a[CTRL_AW-1:0] + 1'b1;
        else         n[PAGE_AW-1:0] = a[PAGE_AW-1:0] + 1'b1;
        return n;
    endfunction

    i2c_mem_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_mem_store #(
        .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES),
        .CTRL_BYTES(CTRL_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk(clk), .rst(rst),
        .buf_clr(ev.start), .buf_we(buf_we), .buf_ctrl(ctrl_sp_q),
        .buf_page(addr_q[ADDR_W-1:PAGE_AW]), .buf_idx(addr_q[PAGE_AW-1:0]),
        .buf_data(sh_q), .commit(commit),
        .rd_ctrl(ctrl_sp_q), .rd_addr(addr_q), .rd_data(rd_data),
        .busy(busy), .wen(wen), .rwen(rwen)
    );

    assign start_det = ev.start;
    assign dev_hit   = !busy && (sh_q[7:1] == ID_MEM || sh_q[7:1] == ID_CTRL);
    assign byte_done = (st_q == ST_RX) && ev.scl_fall && (cnt_q == 4'd8);
    assign buf_we    = byte_done && (kind_q == K_DATA) && !ev.start && !ev.stop;
    // a stop is always preceded by one clock rise, so a clean end leaves cnt at 1
    assign commit    = ev.stop && (st_q == ST_RX) && (kind_q == K_DATA)
                       && (cnt_q == 4'd1) && has_data_q;
    assign sda_oe    = sda_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; kind_q <= K_DEV; cnt_q <= '0;
            sh_q <= '0; txsh_q <= '0; hi_q <= '0; addr_q <= '0;
            ctrl_sp_q <= 1'b0; rd_mode_q <= 1'b0; mack_q <= 1'b0;
            has_data_q <= 1'b0; sda_oe_q <= 1'b0;
        end else if (ev.start) begin
            st_q <= ST_RX; kind_q <= K_DEV; cnt_q <= '0;
            sda_oe_q <= 1'b0; has_data_q <= 1'b0;
        end else if (ev.stop) begin
            st_q <= ST_IDLE; sda_oe_q <= 1'b0; has_data_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_RX: begin
                    if (ev.scl_rise && cnt_q < 4'd8) begin
                        sh_q  <= {sh_q[6:0], ev.sda};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (byte_done) begin
                        st_q     <= ST_RXACK;
                        sda_oe_q <= 1'b1;
                        unique case (kind_q)
                            K_DEV: begin
                                if (dev_hit) begin
                                    ctrl_sp_q <= (sh_q[7:1] == ID_CTRL);
                                    rd_mode_q <= sh_q[0];
                                    kind_q    <= K_AHI;
                                end else begin
                                    st_q     <= ST_IDLE;
                                    sda_oe_q <= 1'b0;
                                end
                            end
                            K_AHI: begin
                                hi_q   <= sh_q[HI_W-1:0];
                                kind_q <= K_ALO;
                            end
                            K_ALO: begin
                                addr_q <= {hi_q, sh_q};
                                kind_q <= K_DATA;
                            end
                            K_DATA: begin
                                addr_q     <= page_step(addr_q, ctrl_sp_q);
                                has_data_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (rd_mode_q) begin
                            st_q     <= ST_TX;
                            txsh_q   <= rd_data;
                            sda_oe_q <= ~rd_data[7];
                        end else begin
                            st_q     <= ST_RX;
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt_q == 4'd7) begin
                            sda_oe_q <= 1'b0;
                            st_q     <= ST_TXACK;
                            addr_q   <= read_step(addr_q, ctrl_sp_q);
                        end else begin
                            cnt_q    <= cnt_q + 1'b1;
                            txsh_q   <= {txsh_q[6:0], 1'b0};
                            sda_oe_q <= ~txsh_q[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (ev.scl_rise) begin
                        mack_q <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_q) begin
                            st_q     <= ST_TX;
                            cnt_q    <= '0;
                            txsh_q   <= rd_data;
                            sda_oe_q <= ~rd_data[7];
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic start_det,
    input logic commit,
    input logic busy,
    input logic wen,
    input logic rwen
);
    assert_release_on_start_R10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    assert_busy_after_commit_R4: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    assert_busy_from_commit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));

    assert_no_commit_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy);

    assert_rwen_needs_wen_R8: assert property (@(posedge clk) disable iff (rst)
        rwen |-> wen);

    assert_rwen_order_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rwen) |-> $past(wen));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk chk_i (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .start_det(start_det),
    .commit(commit), .busy(busy), .wen(wen), .rwen(rwen)
);

// File: tb/i2c_mem_slave_tb.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_err = 0;
    logic [7:0] exp_mem [512];
    logic [7:0] wb [16];
    logic [7:0] rb [16];

    always #2.5 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    i2c_mem_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hw(Q); scl = 1'b1; hw(Q);
        m_low = 1'b1; hw(Q); scl = 1'b0; hw(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hw(Q); scl = 1'b1; hw(Q);
        m_low = 1'b0; hw(Q);
    endtask

    task automatic wbit(input logic b);
        m_low = ~b; hw(Q); scl = 1'b1; hw(2 * Q); scl = 1'b0; hw(Q);
    endtask

    task automatic rbit(output logic b);
        m_low = 1'b0; hw(Q); scl = 1'b1; hw(Q);
        b = sda_line; hw(Q); scl = 1'b0; hw(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic nb;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(nb);
        ack = ~nb;
    endtask

    task automatic rbyte(input logic ack_it, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) rbit(d[i]);
        wbit(~ack_it);
    endtask

    task automatic wr_seq(input logic [7:0] dev, input logic [15:0] a, input int n);
        logic ack;
        bus_start();
        wbyte(dev, ack); wbyte(a[15:8], ack); wbyte(a[7:0], ack);
        for (int i = 0; i < n; i++) begin
            wbyte(wb[i], ack);
            if (dev == 8'hAE) exp_mem[{a[8:4], 4'(a[3:0] + 4'(i))}] = wb[i];
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [7:0] dev, input logic [15:0] a, input int n);
        logic ack;
        bus_start();
        wbyte(dev, ack); wbyte(a[15:8], ack); wbyte(a[7:0], ack);
        bus_start();
        wbyte(dev | 8'h01, ack);
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rb[i]);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        for (int k = 0; k < 60; k++) begin
            bus_start();
            wbyte(8'hAE, ack);
            bus_stop();
            if (ack) break;
            polls++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int polls;
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
        hw(10);
        rst = 1'b0;
        hw(10);
        chk("R10 sda_oe after reset", {15'd0, sda_oe}, 16'd0);

        // current-address read right after reset: address 0, zero content
        bus_start();
        wbyte(8'hAF, ack); chk("R1 data array read id acked", {15'd0, ack}, 16'd1);
        rbyte(1'b0, d);    chk("R10 array zero after reset", {8'd0, d}, 16'd0);
        bus_stop();

        // foreign identifier
        bus_start();
        wbyte(8'hA0, ack); chk("R1 foreign id refused", {15'd0, ack}, 16'd0);
        wbyte(8'hAE, ack); chk("R1 off bus until next start", {15'd0, ack}, 16'd0);
        bus_stop();

        // single byte write and busy polling
        wb[0] = 8'h5A;
        wr_seq(8'hAE, 16'h0005, 1);
        bus_start();
        wbyte(8'hAE, ack); chk("R4 refused during write cycle", {15'd0, ack}, 16'd0);
        bus_stop();
        bus_start();
        wbyte(8'hDE, ack); chk("R4 control id refused during write cycle", {15'd0, ack}, 16'd0);
        bus_stop();
        wait_ready(polls);
        chk("R4 answers again after write cycle", {15'd0, (polls < 60)}, 16'd1);
        chk("R4 write cycle spans several polls", {15'd0, (polls >= 1)}, 16'd1);
        rd_seq(8'hAE, 16'h0005, 1);
        chk("R3 single byte write", {8'd0, rb[0]}, 16'h005A);

        // page write starting mid-page wraps to page start
        for (int i = 0; i < 16; i++) wb[i] = 8'h80 + 8'(i);
        wr_seq(8'hAE, 16'h002C, 16);
        wait_ready(polls);
        rd_seq(8'hAE, 16'h0020, 16);
        for (int i = 0; i < 16; i++)
            chk($sformatf("R3 page wrap offset %0d", i), {8'd0, rb[i]}, {8'd0, exp_mem[9'h020 + 9'(i)]});

        // page sweep, including pages that need the high address byte
        foreach (wb[i]) wb[i] = 8'h00;
        for (int p = 0; p < 4; p++) begin
            int pg;
            pg = (p == 0) ? 1 : (p == 1) ? 17 : (p == 2) ? 31 : 16;
            for (int i = 0; i < 16; i++) wb[i] = 8'(((pg * 16 + i) * 13 + 7) & 255);
            wr_seq(8'hAE, 16'(pg * 16), 16);
            wait_ready(polls);
            rd_seq(8'hAE, 16'(pg * 16), 16);
            for (int i = 0; i < 16; i++)
                chk($sformatf("R2 page %0d byte %0d", pg, i), {8'd0, rb[i]},
                    {8'd0, 8'(((pg * 16 + i) * 13 + 7) & 255)});
        end

        // sequential read across the top of the array
        rd_seq(8'hAE, 16'h01FE, 4);
        chk("R7 read 0x1FE", {8'd0, rb[0]}, {8'd0, exp_mem[9'h1FE]});
        chk("R7 read 0x1FF", {8'd0, rb[1]}, {8'd0, exp_mem[9'h1FF]});
        chk("R7 wrap to 0", {8'd0, rb[2]}, {8'd0, exp_mem[9'h000]});
        chk("R7 then 1", {8'd0, rb[3]}, {8'd0, exp_mem[9'h001]});

        // current-address read continues after the last read byte
        rd_seq(8'hAE, 16'h0004, 1);
        bus_start();
        wbyte(8'hAF, ack);
        rbyte(1'b0, d);
        bus_stop();
        chk("R7 current address read", {8'd0, d}, 16'h005A);

        // stop in the middle of a data byte
        bus_start();
        wbyte(8'hAE, ack); wbyte(8'h00, ack); wbyte(8'h40, ack);
        wbyte(8'h11, ack);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        bus_stop();
        bus_start();
        wbyte(8'hAE, ack); chk("R5 no write cycle after partial byte", {15'd0, ack}, 16'd1);
        bus_stop();
        rd_seq(8'hAE, 16'h0040, 1);
        chk("R5 partial write leaves array", {8'd0, rb[0]}, 16'd0);

        // repeated start cuts a write short
        bus_start();
        wbyte(8'hAE, ack); wbyte(8'h00, ack); wbyte(8'h41, ack);
        wbyte(8'h22, ack);
        bus_start();
        bus_stop();
        bus_start();
        wbyte(8'hAE, ack); chk("R5 no write cycle after restart", {15'd0, ack}, 16'd1);
        bus_stop();
        rd_seq(8'hAE, 16'h0041, 1);
        chk("R5 restart write leaves array", {8'd0, rb[0]}, 16'd0);

        // set current address only
        bus_start();
        wbyte(8'hAE, ack); wbyte(8'h00, ack); wbyte(8'h2A, ack);
        bus_stop();
        bus_start();
        wbyte(8'hAE, ack); chk("R6 no write cycle after address load", {15'd0, ack}, 16'd1);
        bus_stop();
        bus_start();
        wbyte(8'hAF, ack);
        rbyte(1'b0, d);
        bus_stop();
        chk("R6 current read at loaded address", {8'd0, d}, {8'd0, exp_mem[9'h02A]});

        // control space and enable sequence
        wb[0] = 8'h77;
        wr_seq(8'hDE, 16'h0003, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h0003, 1);
        chk("R9 locked control byte unchanged", {8'd0, rb[0]}, 16'd0);
        rd_seq(8'hDE, 16'h000F, 1);
        chk("R8 status after reset", {8'd0, rb[0]}, 16'd0);
        wb[0] = 8'h06;
        wr_seq(8'hDE, 16'h000F, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h000F, 1);
        chk("R8 register enable needs prior write enable", {8'd0, rb[0]}, 16'h0002);
        wr_seq(8'hDE, 16'h000F, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h000F, 1);
        chk("R8 both enables set", {8'd0, rb[0]}, 16'h0006);
        wb[0] = 8'h77;
        wr_seq(8'hDE, 16'h0003, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h0003, 1);
        chk("R9 unlocked control byte written", {8'd0, rb[0]}, 16'h0077);
        rd_seq(8'hDE, 16'h000E, 3);
        chk("R8 control index 14", {8'd0, rb[0]}, 16'd0);
        chk("R8 control index 15 status", {8'd0, rb[1]}, 16'h0006);
        chk("R8 control wrap to 0", {8'd0, rb[2]}, 16'd0);
        wb[0] = 8'h00;
        wr_seq(8'hDE, 16'h000F, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h000F, 1);
        chk("R8 status cleared", {8'd0, rb[0]}, 16'd0);
        wb[0] = 8'h99;
        wr_seq(8'hDE, 16'h0003, 1); wait_ready(polls);
        rd_seq(8'hDE, 16'h0003, 1);
        chk("R9 relocked control byte kept", {8'd0, rb[0]}, 16'h0077);
        chk("R10 bus released at end", {15'd0, sda_oe}, 16'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule